// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a single-port synchronous memory that uses a no-bus-latency protocol. Address and control are registered on the rising clock edge. Read data then flows out of the array combinationally in the cycle that follows that edge. Write data arrives one edge after its address. Because of this offset, a read can be issued on the same edge that takes the previous write's data, and the bus never needs an idle turnaround cycle.

The data word is 36 bits, split into four 9-bit lanes. Each lane has its own active-low write select. Three active-low chip selects must all be asserted to start an access. An advance strobe continues a four-beat burst from the loaded address, either in linear order or in exclusive-or order. While a burst continues, the chip selects and write enable are ignored and the access type stays as it was latched. A clock-enable input freezes every register when it is high, including a write whose data has not yet been taken. Data in and data out are separate ports. A drive flag tells the pad logic when read data is valid on the output.

Top module: `zt_sram`

## Requirements
- R1: An access is loaded only at an edge where `cen_n`=0, `adv`=0 and `cs0_n`, `cs1_n`, `cs2_n` are all 0. At an edge with `adv`=1 while no access is active, nothing starts.
- R2: `we_n` (0 = write, 1 = read) is latched when a burst is loaded. At continuation edges (`adv`=1) the chip selects and `we_n` have no effect on the access type or on whether the access is active.
- R3: Write data on `wdata` is captured at the first enabled edge after the address edge. A new read, write or deselect may be loaded on that same edge.
- R4: Lane i is `wdata[9*i+8:9*i]`. It is written only when `lane_wr_n[i]`=0, sampled together with the beat's address. Unselected lanes keep their contents.
- R5: During the cycle after a write address edge, `rd_drive` is 0, whatever the value of `oe_n`.
- R6: After an edge where `cen_n`=0, `adv`=0 and any chip select is 1, `rd_drive` is 0 in the following cycle.
- R7: `rd_drive` is 1 only while `oe_n`=0 and a read is active. `rdata` then shows the word at the address registered at the previous enabled edge.
- R8: The burst beat n (0..3, wrapping) replaces the low two address bits s of the loaded address with (s+n) mod 4 when `seq_xor`=0, or with s xor n when `seq_xor`=1. `seq_xor` is sampled at the load edge. The upper address bits are fixed.
- R9: While `cen_n`=1, no register changes. A pending write takes its data at the next edge where `cen_n`=0.
- R10: A read loaded on the edge that captures a write's data to the same address returns the newly written lanes.
- R11: After reset, `rd_drive` is 0 until a read has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| cen_n | input | 1 | Clock enable, active low; high freezes all state |
| cs0_n | input | 1 | Chip select 0, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| cs2_n | input | 1 | Chip select 2, active low |
| adv | input | 1 | 0 loads a new address, 1 advances the burst |
| we_n | input | 1 | 0 write, 1 read; latched at load |
| lane_wr_n | input | LANES | Per-lane write select, active low |
| oe_n | input | 1 | Output enable, active low |
| seq_xor | input | 1 | Burst order at load: 0 linear, 1 exclusive-or |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, one edge after its address |
| rdata | output | LANES*LANE_W | Flow-through read data |
| rd_drive | output | 1 | Read data is being driven |

## Verification
The hardest state to reach from the ports is a write that has latched its address but has not yet taken its data, with the clock enable held high for several cycles while `wdata` carries wrong values. The stimulus loads a write, stalls it with garbage on the data bus, and then releases the clock enable on the same edge that loads a read of that address. Only the released-edge data may appear. The other hard case is a burst that runs past its fourth beat while the chip selects and write enable toggle. Here a linear six-beat write wraps onto its own start, and exclusive-or and linear read bursts over the same four words then expose both the beat order and the final contents.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cen_n,
  input  logic                      cs0_n,
  input  logic                      cs1_n,
  input  logic                      cs2_n,
  input  logic                      adv,
  input  logic                      we_n,
  input  logic [LANES-1:0]          lane_wr_n,
  input  logic                      oe_n,
  input  logic                      seq_xor,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rd_drive
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0]     mem [DEPTH];
  logic              act, act_wr, b_xor;
  logic [ADDR_W-1:0] act_addr, base;
  logic [LANES-1:0]  act_lane;
  logic [1:0]        beat;

  wire       go    = !cen_n;
  wire       sel   = !cs0_n && !cs1_n && !cs2_n;
  wire       load  = go && !adv;
  wire [1:0] nbeat = beat + 2'd1;
  wire [1:0] lo    = b_xor ? (base[1:0] ^ nbeat) : (base[1:0] + nbeat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= 1'b0;
      act_wr   <= 1'b0;
      act_addr <= '0;
      base     <= '0;
      beat     <= '0;
      b_xor    <= 1'b0;
      act_lane <= '1;
    end else if (go) begin
      act_lane <= lane_wr_n;
      if (load) begin
        act      <= sel;
        act_wr   <= sel && !we_n;
        act_addr <= addr;
        base     <= addr;
        beat     <= '0;
        b_xor    <= seq_xor;
      end else if (act) begin
        act_addr <= {base[ADDR_W-1:2], lo};
        beat     <= nbeat;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (go && act && act_wr)
      for (int i = 0; i < LANES; i++)
        if (!act_lane[i]) mem[act_addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
  end

  assign rdata    = mem[act_addr];
  assign rd_drive = act && !act_wr && !oe_n;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cen_n,
  input logic                    cs0_n,
  input logic                    cs1_n,
  input logic                    cs2_n,
  input logic                    adv,
  input logic                    we_n,
  input logic                    oe_n,
  input logic [LANES*LANE_W-1:0] rdata,
  input logic                    rd_drive
);
  wire all_sel = !cs0_n && !cs1_n && !cs2_n;

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv && all_sel && !we_n) |=> !rd_drive); // R5
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv && !all_sel) |=> !rd_drive); // R6
  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rd_drive); // R7
  AST_READ_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv && all_sel && we_n) |=> (rd_drive == !oe_n)); // R1
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> $stable(rdata)); // R9
  AST_BURST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv && rd_drive) |=> (rd_drive || oe_n)); // R2
endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) chk_i (.*);

// File: tb/zt_sram_tb_top.sv
module zt_sram_tb_top;
  logic clk = 0, rst_n = 0;
  logic cen_n = 1, cs0_n = 1, cs1_n = 1, cs2_n = 1, adv = 0, we_n = 1, oe_n = 1, seq_xor = 0;
  logic [3:0]  lane_wr_n = 4'hF;
  logic [9:0]  addr = 0;
  logic [35:0] wdata = 0, rdata;
  logic        rd_drive;
  int checks = 0, errors = 0;
  bit done = 0;
  string cur_tag = "R11";

  always #2 clk = ~clk;

  zt_sram dut_i (.*);

  typedef struct { bit drv; logic [35:0] dat; string tag; } exp_t;
  exp_t q[$];

  logic [35:0] ref_mem [1024];
  bit m_act = 0, m_wr = 0, m_xor = 0;
  logic [9:0] m_addr = 0, m_base = 0;
  logic [1:0] m_beat = 0;
  logic [3:0] m_ln = 4'hF;

  task automatic cyc(input bit cen, input bit a_dv, input bit [2:0] cs, input bit we,
                     input bit [3:0] ln, input bit oe, input bit md,
                     input logic [9:0] a, input logic [35:0] d);
    exp_t e;
    cen_n = cen; adv = a_dv; {cs2_n, cs1_n, cs0_n} = cs; we_n = we;
    lane_wr_n = ln; oe_n = oe; seq_xor = md; addr = a; wdata = d;
    @(posedge clk);
    if (!cen) begin
      if (m_act && m_wr)
        for (int i = 0; i < 4; i++)
          if (!m_ln[i]) ref_mem[m_addr][i*9 +: 9] = d[i*9 +: 9];
      if (!a_dv) begin
        m_act = (cs == 3'b000); m_wr = m_act && !we; m_addr = a; m_base = a;
        m_beat = 0; m_xor = md;
      end else if (m_act) begin
        m_beat = m_beat + 2'd1;
        m_addr = {m_base[9:2], m_xor ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat)};
      end
      m_ln = ln;
    end
    e.drv = m_act && !m_wr && !oe;
    e.dat = ref_mem[m_addr];
    e.tag = cur_tag;
    q.push_back(e);
    @(negedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rd_drive !== e.drv || (e.drv && rdata !== e.dat)) begin
        errors++;
        $display("FAIL %s drive=%0b data=%h expected drive=%0b data=%h",
                 e.tag, rd_drive, rdata, e.drv, e.dat);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam bit [2:0] ON = 3'b000;

  initial begin
    for (int i = 0; i < 1024; i++) ref_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    cur_tag = "R11";
    cyc(1, 0, ON, 1, 4'hF, 0, 0, 0, 0);
    cyc(1, 0, ON, 1, 4'hF, 0, 0, 0, 0);
    cur_tag = "R3";
    cyc(0, 0, ON, 0, 4'h0, 0, 0, 10'd5, 0);
    cyc(0, 0, 3'b111, 1, 4'hF, 0, 0, 0, 36'h1_2345_6789);
    cur_tag = "R7";
    cyc(0, 0, ON, 1, 4'hF, 0, 0, 10'd5, 0);
    cur_tag = "R5";
    cyc(0, 0, ON, 0, 4'b0101, 0, 0, 10'd5, 0);
    cur_tag = "R10";
    cyc(0, 0, ON, 1, 4'hF, 0, 0, 10'd5, 36'hA_BCDE_F012);
    cur_tag = "R4";
    cyc(0, 0, 3'b111, 1, 4'hF, 0, 0, 0, 0);
    cyc(0, 0, ON, 1, 4'hF, 0, 0, 10'd5, 0);
    cur_tag = "R7";
    cyc(0, 0, ON, 1, 4'hF, 1, 0, 10'd5, 0);
    cur_tag = "R6";
    cyc(0, 0, 3'b010, 1, 4'hF, 0, 0, 10'd5, 0);
    cyc(0, 0, ON, 1, 4'hF, 0, 0, 10'd5, 0);
    cyc(0, 0, 3'b100, 1, 4'hF, 0, 0, 10'd5, 0);
    cyc(0, 0, ON, 1, 4'hF, 0, 0, 10'd5, 0);
    cyc(0, 0, 3'b001, 1, 4'hF, 0, 0, 10'd5, 0);
    cur_tag = "R2";
    cyc(0, 0, ON, 0, 4'h0, 0, 0, 10'd6, 0);
    cyc(0, 1, 3'b101, 1, 4'h0, 0, 1, 10'd0, 36'h0_0000_0001);
    cyc(0, 1, 3'b111, 0, 4'h0, 0, 0, 10'd0, 36'h0_0000_0002);
    cyc(0, 1, ON, 1, 4'h0, 0, 1, 10'd0, 36'h0_0000_0003);
    cyc(0, 1, 3'b010, 1, 4'h0, 0, 0, 10'd0, 36'h0_0000_0004);
    cyc(0, 1, ON, 0, 4'h0, 0, 0, 10'd0, 36'h0_0000_0005);
    cyc(0, 0, 3'b111, 1, 4'hF, 0, 0, 10'd0, 36'h0_0000_0006);
    cur_tag = "R8";
    cyc(0, 0, ON, 1, 4'hF, 0, 1, 10'd7, 0);
    cyc(0, 1, 3'b111, 0, 4'h0, 0, 0, 10'd0, 0);
    cyc(0, 1, 3'b111, 0, 4'h0, 0, 0, 10'd0, 0);
    cyc(0, 1, 3'b011, 0, 4'h0, 0, 0, 10'd0, 0);
    cyc(0, 0, ON, 1, 4'hF, 0, 0, 10'd5, 0);
    cyc(0, 1, ON, 1, 4'hF, 0, 1, 10'd0, 0);
    cyc(0, 1, ON, 1, 4'hF, 0, 1, 10'd0, 0);
    cyc(0, 1, ON, 1, 4'hF, 0, 1, 10'd0, 0);
    cyc(0, 1, ON, 1, 4'hF, 0, 1, 10'd0, 0);
    cur_tag = "R9";
    cyc(0, 0, ON, 0, 4'h0, 0, 0, 10'd9, 0);
    cyc(1, 0, ON, 1, 4'hF, 0, 0, 10'd3, 36'hF_FFFF_FFFF);
    cyc(1, 0, ON, 1, 4'hF, 0, 0, 10'd3, 36'h0_DEAD_0000);
    cyc(0, 0, ON, 1, 4'hF, 0, 0, 10'd9, 36'h5_A5A5_A5A5);
    cyc(1, 0, 3'b111, 0, 4'h0, 0, 0, 10'd4, 36'h0);
    cyc(1, 1, ON, 0, 4'h0, 0, 0, 10'd4, 36'h0);
    cur_tag = "R1";
    cyc(0, 0, 3'b111, 1, 4'hF, 0, 0, 10'd9, 0);
    cyc(0, 1, ON, 1, 4'hF, 0, 0, 10'd9, 0);
    cyc(0, 1, ON, 0, 4'hF, 0, 0, 10'd9, 0);
    cyc(0, 0, ON, 1, 4'hF, 0, 0, 10'd9, 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule